// File: doc/BRIEF.md
# Pulse-Width-Coded Motor Command Transmitter

This block drives one output pin with a repeating serial frame that tells a motor speed controller what to do. Each frame holds 16 bits. The top 11 bits are the command value. The next bit is the telemetry request, which is always sent as zero. The last 4 bits are a checksum. Every bit takes one fixed bit period. The period starts high, and the length of the high part tells a one from a zero. After the last bit the line stays low for a fixed number of empty bit periods. The same frame is then sent again, and this goes on until a new command arrives.

Commands enter through a valid/ready stream. A holding slot takes one command, and `cmd_ready` stays low while that slot is full. The held command becomes active only at a frame boundary, so a frame already on the line is never changed. The host must keep `cmd_valid` and `cmd_data` steady until it sees `cmd_ready` high at a clock edge. `rate_sel` is a plain control input that the block reads at each frame boundary. At start-up the block sends command 0, the disarm/idle value. Values 48 to 2047 are throttle settings.

Top module: `dshot_tx`

## Requirements
- R1: Each frame is 16 bits, sent most significant bit first. Frame bits 15..5 carry the command, bit 4 is the telemetry request and is always 0, and bits 3..0 carry the checksum, also most significant bit first.
- R2: Let v = (command << 1), a 12-bit value. The checksum is the low 4 bits of v XOR (v >> 4) XOR (v >> 8).
- R3: The bit period P is floor(CLK_HZ / rate) clock cycles. A bit starts high in the first cycle of its period and then goes low for the rest of the period. The high time is floor(P·ONE_PCT/100) cycles for a one and floor(P·ZERO_PCT/100) cycles for a zero.
- R4: `rate_sel` selects the bit rate: 0 gives 150 kbit/s, 1 gives 300 kbit/s, and 2 or 3 give 600 kbit/s. The value present at the clock edge that starts a frame applies to that whole frame.
- R5: After the 16 data bits the output stays low for whole bit periods: GAP_SLOW_SLOTS periods at 150 kbit/s and GAP_FAST_SLOTS periods at the two faster rates. Then the next frame starts at once.
- R6: `frame_done` is high for exactly one clock, in the last cycle of each gap, and at no other time.
- R7: During reset and in the first cycle after reset, `pwm_out` and `frame_done` are low and `cmd_ready` is high. The first frame starts one clock after reset is released and carries command 0.
- R8: A command is accepted at an edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is then low until the next frame start. The accepted command first appears in the frame that starts at the first frame boundary after the accepting edge. The frame in progress at that time is unchanged.
- R9: When no new command is accepted, the same frame is sent again and again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered on cmd_data |
| cmd_ready | output | 1 | The holding slot is empty and can accept a command |
| cmd_data | input | 11 | Command value |
| rate_sel | input | 2 | Bit-rate select, read at each frame start |
| pwm_out | output | 1 | Pulse-width-coded serial output |
| frame_done | output | 1 | One-clock pulse in the last cycle of each gap |

## Verification
The bench builds the block with CLK_HZ = 6 MHz. This gives bit periods of 40, 20 and 10 cycles, so frames at every rate, together with their 6-slot and 14-slot gaps, fit in a few hundred cycles. These values also make both rounding steps visible: 7.1 rounds down to 7 and 3.8 rounds down to 3 at the fastest rate. The duty settings stay at their defaults (71 % and 38 %). Because of this, every frame can be checked cycle by cycle, including:
- commands that arrive exactly at a frame boundary;
- rate changes that apply to the old command's last frame;
- the boundary commands 0, 1, 48 and 2047.

// File: rtl/dshot_pkg.sv
package dshot_pkg;
  localparam int CMD_W   = 11;
  localparam int CRC_W   = 4;
  localparam int FRAME_W = CMD_W + 1 + CRC_W;

  // Checksum over the command shifted up by one (request bit = 0).
  function automatic logic [CRC_W-1:0] frame_crc(input logic [CMD_W-1:0] cmd);
    logic [11:0] v;
    v = {cmd, 1'b0};
    return v[3:0] ^ v[7:4] ^ v[11:8];
  endfunction
endpackage

// File: rtl/dshot_frame_build.sv
module dshot_frame_build
  import dshot_pkg::*;
(
  input  logic [CMD_W-1:0]   cmd,
  output logic [FRAME_W-1:0] frame
);
  // R1 / R2: command, request bit held at 0, checksum nibble
  assign frame = {cmd, 1'b0, frame_crc(cmd)};
endmodule

// File: rtl/dshot_rate_table.sv
module dshot_rate_table #(
  parameter int CLK_HZ         = 48_000_000,
  parameter int ONE_PCT        = 71,
  parameter int ZERO_PCT       = 38,
  parameter int GAP_SLOW_SLOTS = 6,
  parameter int GAP_FAST_SLOTS = 14,
  parameter int CNT_W          = 9,
  parameter int SLOT_W         = 5
) (
  input  logic [1:0]        rate_sel,
  output logic [CNT_W-1:0]  per,
  output logic [CNT_W-1:0]  hi_one,
  output logic [CNT_W-1:0]  hi_zero,
  output logic [SLOT_W-1:0] gap
);
  localparam int BASE_HZ = 150_000;

  logic [CNT_W-1:0]  per_tab  [4];
  logic [CNT_W-1:0]  one_tab  [4];
  logic [CNT_W-1:0]  zero_tab [4];
  logic [SLOT_W-1:0] gap_tab  [4];

  // R4: codes 2 and 3 both select the fastest rate
  for (genvar i = 0; i < 4; i++) begin : g_rate
    localparam int SH = (i > 2) ? 2 : i;
    localparam int P  = CLK_HZ / (BASE_HZ << SH);
    assign per_tab[i]  = CNT_W'(P);
    assign one_tab[i]  = CNT_W'((P * ONE_PCT) / 100);
    assign zero_tab[i] = CNT_W'((P * ZERO_PCT) / 100);
    assign gap_tab[i]  = SLOT_W'((SH == 0) ? GAP_SLOW_SLOTS : GAP_FAST_SLOTS);
  end

  assign per     = per_tab[rate_sel];
  assign hi_one  = one_tab[rate_sel];
  assign hi_zero = zero_tab[rate_sel];
  assign gap     = gap_tab[rate_sel];
endmodule

// File: rtl/dshot_serializer.sv
module dshot_serializer #(
  parameter int FRAME_W = 16,
  parameter int CNT_W   = 9,
  parameter int SLOT_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   per_in,
  input  logic [CNT_W-1:0]   hi_one_in,
  input  logic [CNT_W-1:0]   hi_zero_in,
  input  logic [SLOT_W-1:0]  gap_in,
  output logic               frame_load,
  output logic               frame_done,
  output logic               pwm_out
);
  logic               boot_q;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   per_q, hi_one_q, hi_zero_q, cnt_q;
  logic [SLOT_W-1:0]  gap_q, slot_q;
  logic               last_cyc, last_slot, in_data, wrap;
  logic [CNT_W-1:0]   hi_now;

  assign last_cyc   = (cnt_q == per_q - CNT_W'(1));
  assign last_slot  = (slot_q == SLOT_W'(FRAME_W) + gap_q - SLOT_W'(1));
  assign in_data    = (slot_q < SLOT_W'(FRAME_W));
  assign wrap       = last_cyc && last_slot;
  assign frame_load = boot_q || wrap;
  assign frame_done = !boot_q && wrap;
  assign hi_now     = sh_q[FRAME_W-1] ? hi_one_q : hi_zero_q;
  assign pwm_out    = !boot_q && in_data && (cnt_q < hi_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_q    <= 1'b1;
      sh_q      <= '0;
      per_q     <= '0;
      hi_one_q  <= '0;
      hi_zero_q <= '0;
      gap_q     <= '0;
      slot_q    <= '0;
      cnt_q     <= '0;
    end else if (frame_load) begin
      boot_q    <= 1'b0;
      sh_q      <= frame_in;
      per_q     <= per_in;
      hi_one_q  <= hi_one_in;
      hi_zero_q <= hi_zero_in;
      gap_q     <= gap_in;
      slot_q    <= '0;
      cnt_q     <= '0;
    end else if (last_cyc) begin
      cnt_q  <= '0;
      slot_q <= slot_q + SLOT_W'(1);
      if (in_data) sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R5
  gap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !pwm_out);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  // R8
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_load |=> ($stable(per_q) && $stable(gap_q) && $stable(hi_one_q)));
  // R3
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> (cnt_q == '0));
endmodule

// File: rtl/dshot_tx.sv
module dshot_tx #(
  parameter int CLK_HZ         = 48_000_000,
  parameter int ONE_PCT        = 71,
  parameter int ZERO_PCT       = 38,
  parameter int GAP_SLOW_SLOTS = 6,
  parameter int GAP_FAST_SLOTS = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [10:0] cmd_data,
  input  logic [1:0]  rate_sel,
  output logic        pwm_out,
  output logic        frame_done
);
  import dshot_pkg::*;

  localparam int MAX_GAP = (GAP_SLOW_SLOTS > GAP_FAST_SLOTS) ? GAP_SLOW_SLOTS : GAP_FAST_SLOTS;
  localparam int CNT_W   = $clog2(CLK_HZ / 150_000 + 1);
  localparam int SLOT_W  = $clog2(FRAME_W + MAX_GAP + 1);

  logic [CMD_W-1:0]   cmd_q, pend_q, src_cmd;
  logic               pend_v, frame_load, accept;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   per, hi_one, hi_zero;
  logic [SLOT_W-1:0]  gap;

  assign cmd_ready = !pend_v;
  assign accept    = cmd_valid && cmd_ready;
  assign src_cmd   = pend_v ? pend_q : cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      pend_q <= '0;
      pend_v <= 1'b0;
    end else begin
      if (frame_load && pend_v) begin
        cmd_q  <= pend_q;
        pend_v <= 1'b0;
      end else if (accept) begin
        pend_q <= cmd_data;
        pend_v <= 1'b1;
      end
    end
  end

  dshot_frame_build u_build (.cmd(src_cmd), .frame(frame));

  dshot_rate_table #(
    .CLK_HZ(CLK_HZ), .ONE_PCT(ONE_PCT), .ZERO_PCT(ZERO_PCT),
    .GAP_SLOW_SLOTS(GAP_SLOW_SLOTS), .GAP_FAST_SLOTS(GAP_FAST_SLOTS),
    .CNT_W(CNT_W), .SLOT_W(SLOT_W)
  ) u_rate (
    .rate_sel(rate_sel), .per(per), .hi_one(hi_one), .hi_zero(hi_zero), .gap(gap)
  );

  dshot_serializer #(.FRAME_W(FRAME_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .frame_in(frame), .per_in(per),
    .hi_one_in(hi_one), .hi_zero_in(hi_zero), .gap_in(gap),
    .frame_load(frame_load), .frame_done(frame_done), .pwm_out(pwm_out)
  );

  // R8
  slot_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cmd_ready);
  // R8
  slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_load && !cmd_ready) |=> cmd_ready);
endmodule

// File: tb/dshot_tx_tb.sv
`timescale 1ns/1ps
module dshot_tx_tb;
  localparam int CLK_HZ = 6_000_000;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [10:0] cmd_data = '0;
  logic [1:0]  rate_sel = 2'd2;
  logic cmd_ready, pwm_out, frame_done;
  int checks = 0, errors = 0;
  logic first_ready;

  always #4 clk = ~clk;

  dshot_tx #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .rate_sel(rate_sel), .pwm_out(pwm_out), .frame_done(frame_done)
  );

  function automatic logic [15:0] exp_frame(input int cmd);
    int v, c;
    v = cmd * 2;
    c = (v ^ (v >> 4) ^ (v >> 8)) & 15;
    return 16'((cmd << 5) | c);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Check one frame plus gap; starts sampling at the next falling edge.
  task automatic check_frame(input int cmd, input int ri);
    int sh, per, h1, h0, gap, mism, highs;
    logic [15:0] f;
    sh  = (ri > 2) ? 2 : ri;
    per = CLK_HZ / (150000 << sh);
    h1  = per * 71 / 100;
    h0  = per * 38 / 100;
    gap = (sh == 0) ? 6 : 14;
    f   = exp_frame(cmd);
    for (int b = 0; b < 16; b++) begin
      int hexp;
      hexp = f[15-b] ? h1 : h0;
      mism = 0; highs = 0;
      for (int c = 0; c < per; c++) begin
        @(negedge clk);
        cmd_valid = 1'b0;
        if (b == 0 && c == 0) first_ready = cmd_ready;
        if (pwm_out) highs++;
        if (pwm_out !== (c < hexp)) mism++;
        if (frame_done) mism++;
      end
      chk(mism == 0, $sformatf("R1/R2/R3 cmd %0d rate %0d bit %0d high cycles", cmd, ri, b),
          highs, hexp);
    end
    mism = 0;
    for (int c = 0; c < gap * per; c++) begin
      @(negedge clk);
      if (pwm_out) mism++;
      if (frame_done !== (c == gap * per - 1)) mism++;
    end
    chk(mism == 0, $sformatf("R5/R6 gap cmd %0d rate %0d mismatched cycles", cmd, ri), mism, 0);
  endtask

  // At a frame boundary (frame_done seen): offer a command and a rate.
  // R4: the new rate applies to the frame starting now; R8: the command waits one frame.
  task automatic switch_to(input int old_cmd, input int cmd, input int ri);
    cmd_data  = 11'(cmd);
    rate_sel  = 2'(ri);
    cmd_valid = 1'b1;
    check_frame(old_cmd, ri);
    chk(first_ready == 1'b0, "R8 ready low after accept", int'(first_ready), 0);
    check_frame(cmd, ri);
    chk(first_ready == 1'b1, "R8 ready back after adoption", int'(first_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R9 watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cur, nxt, ri;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(pwm_out == 1'b0 && frame_done == 1'b0, "R7 outputs low in reset", int'(pwm_out), 0);
    chk(cmd_ready == 1'b1, "R7 ready high in reset", int'(cmd_ready), 1);
    rst_n = 1'b1;
    // R7: first frame carries command 0 at the rate present at start
    check_frame(0, 2);
    // R9: repeats unchanged
    check_frame(0, 2);
    cur = 0;
    // Directed corners across rates
    switch_to(cur, 2047, 0); cur = 2047;
    switch_to(cur, 48, 1);   cur = 48;
    switch_to(cur, 1, 3);    cur = 1;
    check_frame(cur, 3);     // R9 repeat
    // Constrained random commands and rates
    for (int i = 0; i < 10; i++) begin
      nxt = 48 + int'($urandom % 2000);
      ri  = int'($urandom % 4);
      switch_to(cur, nxt, ri);
      cur = nxt;
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule